// File: doc/BRIEF.md
# Enable-Framed Serial Command Latch

This block receives write-only control commands over a three-wire serial link: a serial clock, a serial data line and an active-low enable. While the enable is held low, the block samples one data bit on each rising edge of the serial clock. Bits arrive most significant first. When the enable returns high, the block hands one 8-bit command to the register bank, together with a valid pulse that lasts one system clock.

The enable, not a bit count, frames each command. A frame that ends before eight bits have arrived is dropped. A frame that carries more than eight bits keeps only its first eight. All three serial inputs pass through synchronizers into the system clock domain, and their edges are detected there. The system clock must run at least 16 times faster than the serial clock.

Top module: `serial_cmd_latch`

## Requirements
- R1: The first bit sampled in a frame lands in bit 7 of `cmd_word`, and each following bit lands one position lower, down to bit 0.
- R2: Data is taken only at a serial clock rising edge. A change on `ser_dat` while `ser_clk` is high, after its rising edge, does not alter the committed word.
- R3: When `ser_en_n` rises after exactly eight sampled bits, `cmd_vld` pulses once and `cmd_word` carries those eight bits.
- R4: When `ser_en_n` rises after fewer than eight sampled bits, no pulse occurs and `cmd_word` keeps its previous value.
- R5: When a frame carries more than eight serial clock rising edges, only the first eight bits are committed, and they are committed at the enable rise.
- R6: Serial clock edges while `ser_en_n` is high shift nothing and produce no pulse.
- R7: The bit count restarts at every enable falling edge, so an aborted frame leaves nothing behind for the next frame.
- R8: During reset and in the first cycle after it, `cmd_vld` is 0 and `cmd_word` is 0.
- R9: `cmd_vld` is high for exactly one system clock per committed frame.
- R10: If the enable falling edge and a serial clock rising edge are seen in the same system cycle, that bit is taken as the first bit of the new frame.
- R11: `cmd_word` changes only in a cycle where `cmd_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge commits the frame |
| cmd_word | output | 8 | Last committed command |
| cmd_vld | output | 1 | One-cycle pulse marking a new command |

## Verification
Two events can land in the same synchronized cycle: the enable falling edge, which restarts the bit count, and a serial clock rising edge, which shifts in a bit. The bench provokes this by changing `ser_en_n` and `ser_clk` at the same instant, so that both signals pass through identical synchronizer depths. It then sends the remaining seven bits. A design that clears the count but drops the coincident bit sees only seven bits and commits nothing. The bench therefore judges this case by the committed word and the pulse count.

// File: rtl/sclatch_pkg.sv
package sclatch_pkg;
  localparam int DEF_CMD_W  = 8;
  localparam int DEF_SYNC_N = 2;

  // width of a counter that must reach the value n
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sclatch_sync.sv
// Multi-stage synchronizer for a small bundle of asynchronous inputs.
module sclatch_sync #(
  parameter int               W       = 3,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sclatch_edges.sv
// Edge detection on the synchronized serial clock and enable.
module sclatch_edges (
  input  logic clk,
  input  logic rst,
  input  logic sclk_lvl,
  input  logic en_n_lvl,
  output logic sclk_rise,
  output logic en_fall,
  output logic en_rise
);
  logic sclk_q, en_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      en_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk_lvl;
      en_n_q <= en_n_lvl;
    end
  end

  assign sclk_rise = sclk_lvl & ~sclk_q;
  assign en_fall   = ~en_n_lvl & en_n_q;   // enable asserted (goes low)
  assign en_rise   = en_n_lvl & ~en_n_q;   // enable released (goes high)
endmodule

// File: rtl/sclatch_shift.sv
// Shift register with a bit counter that saturates at CMD_W.
module sclatch_shift #(
  parameter int CMD_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_low,
  input  logic             en_fall,
  input  logic             sclk_rise,
  input  logic             dat,
  output logic [CMD_W-1:0] shreg,
  output logic             cnt_full
);
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign cnt_full = (cnt == CNT_W'(CMD_W));
  // a fresh frame always accepts its first bit, even if the old count was full
  assign take = en_low & sclk_rise & (en_fall | ~cnt_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      shreg <= '0;
    end else begin
      if (take) shreg <= {shreg[CMD_W-2:0], dat};
      if (en_fall)   cnt <= take ? CNT_W'(1) : '0;
      else if (take) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sclatch_commit.sv
// Output register: loads a complete frame on enable release.
module sclatch_commit #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_rise,
  input  logic             cnt_full,
  input  logic [CMD_W-1:0] shreg,
  output logic [CMD_W-1:0] cmd_word,
  output logic             cmd_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_word <= '0;
      cmd_vld  <= 1'b0;
    end else begin
      cmd_vld <= en_rise & cnt_full;
      if (en_rise & cnt_full) cmd_word <= shreg;
    end
  end
endmodule

// File: rtl/serial_cmd_latch.sv
module serial_cmd_latch #(
  parameter int CMD_W  = sclatch_pkg::DEF_CMD_W,
  parameter int SYNC_N = sclatch_pkg::DEF_SYNC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_en_n,
  output logic [CMD_W-1:0] cmd_word,
  output logic             cmd_vld
);
  localparam int         CNT_W = sclatch_pkg::cnt_bits(CMD_W);
  localparam logic [2:0] IDLE  = 3'b100;   // {en_n, dat, clk} at rest

  logic [2:0]       raw, lvl;
  logic             sclk_rise, en_fall, en_rise, cnt_full;
  logic [CMD_W-1:0] shreg;

  assign raw = {ser_en_n, ser_dat, ser_clk};

  sclatch_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(lvl)
  );

  sclatch_edges u_edges (
    .clk(clk), .rst(rst), .sclk_lvl(lvl[0]), .en_n_lvl(lvl[2]),
    .sclk_rise(sclk_rise), .en_fall(en_fall), .en_rise(en_rise)
  );

  sclatch_shift #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .en_low(~lvl[2]), .en_fall(en_fall),
    .sclk_rise(sclk_rise), .dat(lvl[1]), .shreg(shreg), .cnt_full(cnt_full)
  );

  sclatch_commit #(.CMD_W(CMD_W)) u_commit (
    .clk(clk), .rst(rst), .en_rise(en_rise), .cnt_full(cnt_full),
    .shreg(shreg), .cmd_word(cmd_word), .cmd_vld(cmd_vld)
  );
endmodule

// File: rtl/sclatch_chk.sv
module sclatch_chk #(
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_vld,
  input logic [CMD_W-1:0] cmd_word,
  input logic             cnt_full,
  input logic             en_rise
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |=> !cmd_vld);

  a_r4_full_frame_only: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |-> $past(cnt_full));

  a_r3_commit_on_release: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |-> $past(en_rise));

  a_r11_word_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld |-> $stable(cmd_word));

  a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cmd_vld && cmd_word == '0));
endmodule

bind serial_cmd_latch sclatch_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_word(cmd_word),
  .cnt_full(cnt_full), .en_rise(en_rise)
);

// File: tb/test_serial_cmd_latch.sv
module test_serial_cmd_latch;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;   // serial half period in system cycles
  localparam int NVEC       = 9;
  // {bit count[20:16], frame bits MSB first [15:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {5'd8,  16'hA500}, {5'd8, 16'h3C00}, {5'd5, 16'hF800},
    {5'd12, 16'h96F0}, {5'd1, 16'h8000}, {5'd9, 16'h0180},
    {5'd8,  16'hFF00}, {5'd7, 16'h0000}, {5'd8, 16'h0000}
  };

  logic       clk = 1'b0, rst = 1'b1;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
  logic [7:0] cmd_word;
  logic       cmd_vld;

  int n_chk = 0, n_err = 0, vld_seen = 0, run = 0, max_run = 0;
  int exp_cnt = 0;
  logic [7:0] exp_word = 8'h00;

  serial_cmd_latch i_serial_cmd_latch (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en_n(ser_en_n), .cmd_word(cmd_word), .cmd_vld(cmd_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && cmd_vld) begin
      vld_seen++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [15:0] data,
                      input bit wiggle, input bit collide);
    int start;
    if (collide) begin
      ser_dat = data[15];
      cyc(2);
      ser_en_n = 1'b0;
      ser_clk  = 1'b1;          // same instant as the enable fall
      cyc(HALF);
      ser_clk = 1'b0;
      start = 1;
    end else begin
      ser_en_n = 1'b0;
      cyc(4);
      start = 0;
    end
    for (int i = start; i < nbits; i++) begin
      ser_dat = data[15-i];
      cyc(HALF);
      ser_clk = 1'b1;
      if (wiggle) begin
        cyc(2);
        ser_dat = ~data[15-i];
        cyc(HALF-2);
      end else cyc(HALF);
      ser_clk = 1'b0;
    end
    cyc(HALF);
    ser_en_n = 1'b1;
    cyc(12);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    cyc(4);
    check("R8 vld in reset", cmd_vld, 0);
    check("R8 word in reset", cmd_word, 0);
    rst = 1'b0;
    cyc(1);
    check("R8 word after reset", cmd_word, 0);

    for (int v = 0; v < NVEC; v++) begin
      int nb;
      nb = int'(VEC[v][20:16]);
      send(nb, VEC[v][15:0], v[0], 1'b0);
      if (nb >= 8) begin
        exp_cnt++;
        exp_word = VEC[v][15:8];
      end
      if (nb < 8)      check("R4 short frame pulses", vld_seen, exp_cnt);
      else if (nb > 8) check("R5 long frame pulses", vld_seen, exp_cnt);
      else             check("R3 full frame pulses", vld_seen, exp_cnt);
      check(v[0] ? "R2 R1 word with data change while high" : "R1 R11 word",
            cmd_word, exp_word);
    end

    // R6: clock edges with enable high
    ser_dat = 1'b1;
    for (int k = 0; k < 5; k++) begin
      ser_clk = 1'b1; cyc(HALF);
      ser_clk = 1'b0; cyc(HALF);
    end
    check("R6 no pulse while idle", vld_seen, exp_cnt);
    check("R6 word held while idle", cmd_word, exp_word);
    send(8, 16'h5A00, 1'b0, 1'b0);
    exp_cnt++; exp_word = 8'h5A;
    check("R6 next frame clean", cmd_word, exp_word);

    // R7: aborted frame, then a full one
    send(3, 16'hE000, 1'b0, 1'b0);
    check("R7 abort no pulse", vld_seen, exp_cnt);
    send(8, 16'h8100, 1'b0, 1'b0);
    exp_cnt++; exp_word = 8'h81;
    check("R7 restart pulses", vld_seen, exp_cnt);
    check("R7 restart word", cmd_word, exp_word);

    // R10: enable fall and first clock rise together
    send(8, 16'hC300, 1'b0, 1'b1);
    exp_cnt++; exp_word = 8'hC3;
    check("R10 collision pulses", vld_seen, exp_cnt);
    check("R10 collision word", cmd_word, exp_word);

    check("R9 pulse width", max_run, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule